// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block holds the 16-bit program counter of a small accumulator-style core and works out where the next fetch goes. Each time the sequencer asserts the step enable, the unit loads one of these addresses:

- the sequential address, which is the counter plus the length of the current instruction;
- a relative target;
- a page-local absolute target;
- a full 16-bit target;
- an indirect target formed from the accumulator and the data pointer.

Condition evaluation happens outside the block. The block only receives a single taken flag.

A second combinational output gives the byte address for constant-table reads from code memory. That address is either the accumulator plus the data pointer, or the accumulator plus the address of the following instruction. Forming this address never moves the counter.

For subroutine calls, the block presents the return address (the address of the following instruction) together with a push request. An external stack unit consumes both.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `pc_q` reads 0x0000.
- R2: On a clock edge with `step_en` low, `pc_q` keeps its value.
- R3: With `xfer_kind` = 0 (sequential), a step loads `pc_q + ilen`, where `ilen` is 1 to 3. The result wraps modulo 2^16.
- R4: With `xfer_kind` = 1 (relative, always taken), a step loads the following-instruction address plus a sign-extended 8-bit offset. The offset is `opnd_a` when `ilen` = 2 and `opnd_b` when `ilen` = 3.
- R5: With `xfer_kind` = 2 (conditional relative), a step loads the R4 target when `cond_taken` is 1. It loads the sequential address when `cond_taken` is 0.
- R6: With `xfer_kind` = 3 (page-absolute), a step loads an address assembled as follows:
  - bits [15:11] come from the following-instruction address;
  - bits [10:8] come from `opcode[7:5]`;
  - bits [7:0] come from `opnd_a`.
- R7: With `xfer_kind` = 4 (long), a step loads `{opnd_a, opnd_b}`, with `opnd_a` as the high byte.
- R8: With `xfer_kind` = 5 (indirect), a step loads the zero-extended `acc` plus `dptr`, modulo 2^16.
- R9: `tbl_addr` is formed combinationally, and driving it has no effect on `pc_q`:
  - with `tbl_sel` = 0, it equals `acc + dptr`;
  - with `tbl_sel` = 1, it equals `acc` plus the following-instruction address.
- R10: `ret_addr` always equals `pc_q + ilen`. `push_req` equals `step_en & is_call`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Load the next address on this edge |
| ilen | input | 2 | Current instruction length in bytes (1..3) |
| xfer_kind | input | 3 | Transfer kind: 0 seq, 1 rel, 2 cond rel, 3 page-abs, 4 long, 5 indirect |
| cond_taken | input | 1 | Branch condition result for kind 2 |
| is_call | input | 1 | Current instruction is a call |
| opcode | input | 8 | Opcode byte |
| opnd_a | input | 8 | First operand byte |
| opnd_b | input | 8 | Second operand byte |
| acc | input | 8 | Accumulator value |
| dptr | input | 16 | Data pointer value |
| tbl_sel | input | 1 | Table base: 0 data pointer, 1 next-instruction address |
| pc_q | output | 16 | Current program counter |
| tbl_addr | output | 16 | Code-table read address |
| ret_addr | output | 16 | Return address for the stack unit |
| push_req | output | 1 | Request to push `ret_addr` |

## Verification
The bench builds the unit with the default widths:

- 16-bit addresses;
- 8-bit bytes;
- an 11-bit page.

At these widths, wrap-around at the top of the address space can be reached in one step, from 0xFFFE or through an accumulator plus data pointer sum above 0xFFFF. A page-absolute jump placed just below a 2 KB boundary also shows that the upper bits come from the following instruction, not the jump's own address.

Negative offsets at the -128 extreme, and a two-byte self-loop, exercise the sign extension and the choice of offset byte by instruction length.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  typedef enum logic [2:0] {
    XF_SEQ   = 3'd0,
    XF_REL   = 3'd1,
    XF_RELC  = 3'd2,
    XF_PAGE  = 3'd3,
    XF_LONG  = 3'd4,
    XF_IND   = 3'd5
  } xfer_e;

endpackage

// File: rtl/pcu_seq_add.sv
module pcu_seq_add #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 2
) (
  input  logic [ADDR_W-1:0] pc_cur,
  input  logic [LEN_W-1:0]  len,
  output logic [ADDR_W-1:0] seq_next
);

  localparam int PAD_W = ADDR_W - LEN_W;

  logic [ADDR_W-1:0] len_ext;

  always_comb begin
    len_ext  = {{PAD_W{1'b0}}, len};
    seq_next = pc_cur + len_ext;
  end

endmodule

// File: rtl/pcu_target_gen.sv
module pcu_target_gen
  import pcu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 11,
  parameter int LEN_W  = 2
) (
  input  xfer_e             kind,
  input  logic              taken,
  input  logic [LEN_W-1:0]  len,
  input  logic [ADDR_W-1:0] seq_next,
  input  logic [DATA_W-1:0] opcode,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [DATA_W-1:0] acc,
  input  logic [ADDR_W-1:0] dptr,
  output logic [ADDR_W-1:0] pc_d
);

  localparam int EXT_W  = ADDR_W - DATA_W;
  localparam int HI_W   = PAGE_W - DATA_W;
  localparam int KEEP_W = ADDR_W - PAGE_W;
  localparam int CAT_W  = 2 * DATA_W;

  logic [DATA_W-1:0] rel_off;
  logic [ADDR_W-1:0] rel_tgt;
  logic [ADDR_W-1:0] page_tgt;
  logic [ADDR_W-1:0] long_tgt;
  logic [ADDR_W-1:0] ind_tgt;
  logic [CAT_W-1:0]  long_cat;

  // Offset byte is the last byte of the instruction.
  always_comb begin
    if (len == LEN_W'(3)) rel_off = op_b;
    else                  rel_off = op_a;
    rel_tgt = seq_next + {{EXT_W{rel_off[DATA_W-1]}}, rel_off};
  end

  generate
    if (HI_W > 0) begin : g_page_hi
      always_comb begin
        page_tgt = {seq_next[ADDR_W-1 -: KEEP_W], opcode[DATA_W-1 -: HI_W], op_a};
      end
    end else begin : g_page_flat
      always_comb begin
        page_tgt = {seq_next[ADDR_W-1 -: KEEP_W], op_a[PAGE_W-1:0]};
      end
    end
  endgenerate

  always_comb begin
    long_cat = {op_a, op_b};
    long_tgt = long_cat[ADDR_W-1:0];
    ind_tgt  = dptr + {{EXT_W{1'b0}}, acc};
  end

  always_comb begin
    case (kind)
      XF_REL:  pc_d = rel_tgt;
      XF_RELC: pc_d = taken ? rel_tgt : seq_next;
      XF_PAGE: pc_d = page_tgt;
      XF_LONG: pc_d = long_tgt;
      XF_IND:  pc_d = ind_tgt;
      default: pc_d = seq_next;
    endcase
  end

endmodule

// File: rtl/pcu_tbl_addr.sv
module pcu_tbl_addr #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              sel_pc,
  input  logic [DATA_W-1:0] acc,
  input  logic [ADDR_W-1:0] dptr,
  input  logic [ADDR_W-1:0] seq_next,
  output logic [ADDR_W-1:0] tbl_addr
);

  localparam int EXT_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] base;

  always_comb begin
    base     = sel_pc ? seq_next : dptr;
    tbl_addr = base + {{EXT_W{1'b0}}, acc};
  end

endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
  import pcu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [1:0]        ilen,
  input  logic [2:0]        xfer_kind,
  input  logic              cond_taken,
  input  logic              is_call,
  input  logic [DATA_W-1:0] opcode,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] acc,
  input  logic [ADDR_W-1:0] dptr,
  input  logic              tbl_sel,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] tbl_addr,
  output logic [ADDR_W-1:0] ret_addr,
  output logic              push_req
);

  localparam int LEN_W = 2;

  xfer_e             kind;
  logic [ADDR_W-1:0] seq_next;
  logic [ADDR_W-1:0] tgt;
  logic [ADDR_W-1:0] pc_nxt;

  assign kind = xfer_e'(xfer_kind);

  pcu_seq_add #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
    .pc_cur  (pc_q),
    .len     (ilen),
    .seq_next(seq_next)
  );

  pcu_target_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_tgt (
    .kind    (kind),
    .taken   (cond_taken),
    .len     (ilen),
    .seq_next(seq_next),
    .opcode  (opcode),
    .op_a    (opnd_a),
    .op_b    (opnd_b),
    .acc     (acc),
    .dptr    (dptr),
    .pc_d    (tgt)
  );

  pcu_tbl_addr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tbl (
    .sel_pc  (tbl_sel),
    .acc     (acc),
    .dptr    (dptr),
    .seq_next(seq_next),
    .tbl_addr(tbl_addr)
  );

  // Next-state process
  always_comb begin
    pc_nxt = pc_q;
    if (step_en) pc_nxt = tgt;
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_nxt;
  end

  assign ret_addr = seq_next;
  assign push_req = step_en & is_call;

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(pc_q));

  // R5
  cond_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && xfer_kind == 3'd2 && !cond_taken) |=> pc_q == $past(ret_addr));

  // R6
  page_keep_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && xfer_kind == 3'd3) |=>
      pc_q[ADDR_W-1:PAGE_W] == $past(seq_next[ADDR_W-1:PAGE_W]));

  // R7
  long_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && xfer_kind == 3'd4) |=> pc_q == ADDR_W'({$past(opnd_a), $past(opnd_b)}));

  // R8
  indirect_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && xfer_kind == 3'd5) |=>
      pc_q == $past(dptr) + {{(ADDR_W-DATA_W){1'b0}}, $past(acc)});

  // R3
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && xfer_kind == 3'd0) |=>
      pc_q == $past(pc_q) + {{(ADDR_W-2){1'b0}}, $past(ilen)});

endmodule

// File: tb/pc_next_unit_bench.sv
module pc_next_unit_bench;

  logic        clk;
  logic        rst_n;
  logic        step_en;
  logic [1:0]  ilen;
  logic [2:0]  xfer_kind;
  logic        cond_taken;
  logic        is_call;
  logic [7:0]  opcode;
  logic [7:0]  opnd_a;
  logic [7:0]  opnd_b;
  logic [7:0]  acc;
  logic [15:0] dptr;
  logic        tbl_sel;
  logic [15:0] pc_q;
  logic [15:0] tbl_addr;
  logic [15:0] ret_addr;
  logic        push_req;

  int n_checks;
  int n_fail;
  bit done;

  pc_next_unit u_pc_next_unit (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .ilen(ilen),
    .xfer_kind(xfer_kind), .cond_taken(cond_taken), .is_call(is_call),
    .opcode(opcode), .opnd_a(opnd_a), .opnd_b(opnd_b), .acc(acc),
    .dptr(dptr), .tbl_sel(tbl_sel), .pc_q(pc_q), .tbl_addr(tbl_addr),
    .ret_addr(ret_addr), .push_req(push_req)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // start, len, kind, cond, opcode, op_a, op_b, acc, dptr, expected
  localparam int NV = 13;
  localparam logic [85:0] VEC [NV] = '{
    {16'h1234, 2'd1, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 16'h1235}, // R3
    {16'hFFFE, 2'd3, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 16'h0001}, // R3 wrap
    {16'h0100, 2'd2, 3'd1, 1'b0, 8'h00, 8'h10, 8'h00, 8'h00, 16'h0000, 16'h0112}, // R4
    {16'h0100, 2'd2, 3'd1, 1'b0, 8'h00, 8'hFE, 8'h77, 8'h00, 16'h0000, 16'h0100}, // R4 self loop
    {16'h2000, 2'd3, 3'd2, 1'b1, 8'h00, 8'h33, 8'h80, 8'h00, 16'h0000, 16'h1F83}, // R5 taken -128
    {16'h2000, 2'd3, 3'd2, 1'b0, 8'h00, 8'h33, 8'h80, 8'h00, 16'h0000, 16'h2003}, // R5 not taken
    {16'h0050, 2'd2, 3'd2, 1'b1, 8'h00, 8'h05, 8'hF0, 8'h00, 16'h0000, 16'h0057}, // R5 two-byte
    {16'h37FE, 2'd2, 3'd3, 1'b0, 8'hE1, 8'h55, 8'h00, 8'h00, 16'h0000, 16'h3F55}, // R6 boundary
    {16'h0000, 2'd2, 3'd3, 1'b0, 8'h01, 8'h23, 8'h00, 8'h00, 16'h0000, 16'h0023}, // R6
    {16'h4444, 2'd3, 3'd4, 1'b0, 8'h00, 8'hAB, 8'hCD, 8'h00, 16'h0000, 16'hABCD}, // R7
    {16'h0010, 2'd1, 3'd5, 1'b0, 8'h00, 8'h00, 8'h00, 8'hFF, 16'hFFF0, 16'h00EF}, // R8 wrap
    {16'h0010, 2'd1, 3'd5, 1'b0, 8'h00, 8'h00, 8'h00, 8'h10, 16'h1000, 16'h1010}, // R8
    {16'hFFFF, 2'd1, 3'd2, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 16'h0000}  // R5 wrap
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    step_en = 0; ilen = 2'd1; xfer_kind = 3'd0; cond_taken = 0; is_call = 0;
    opcode = 0; opnd_a = 0; opnd_b = 0; acc = 0; dptr = 0; tbl_sel = 0;
  endtask

  task automatic set_pc(input logic [15:0] a);
    @(negedge clk);
    step_en = 1; xfer_kind = 3'd4; ilen = 2'd3; opnd_a = a[15:8]; opnd_b = a[7:0];
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    n_checks = 0; n_fail = 0; done = 0;
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", pc_q, 16'h0000);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", pc_q, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      set_pc(VEC[i][85:70]);
      ilen = VEC[i][69:68]; xfer_kind = VEC[i][67:65]; cond_taken = VEC[i][64];
      opcode = VEC[i][63:56]; opnd_a = VEC[i][55:48]; opnd_b = VEC[i][47:40];
      acc = VEC[i][39:32]; dptr = VEC[i][31:16]; step_en = 1;
      #1;
      chk("R10 ret_addr", ret_addr, VEC[i][85:70] + {14'd0, VEC[i][69:68]});
      @(negedge clk);
      chk("R3-R8 vector target", pc_q, VEC[i][15:0]);
      idle_inputs();
    end

    // R2: no step, inputs asking for a long jump are ignored
    set_pc(16'h5A5A);
    xfer_kind = 3'd4; opnd_a = 8'h12; opnd_b = 8'h34; step_en = 0;
    @(negedge clk); @(negedge clk);
    chk("R2 hold", pc_q, 16'h5A5A);

    // R9: table address with data pointer base
    acc = 8'h20; dptr = 16'h1FF0; tbl_sel = 0; #1;
    chk("R9 A+DPTR", tbl_addr, 16'h2010);
    // R9: table address with next-instruction base
    ilen = 2'd1; tbl_sel = 1; acc = 8'hF0; #1;
    chk("R9 A+next", tbl_addr, 16'h5A5B + 16'h00F0);
    @(negedge clk);
    chk("R9 pc untouched", pc_q, 16'h5A5A);
    idle_inputs();

    // R10: call push request and return address
    set_pc(16'h37FE);
    ilen = 2'd2; xfer_kind = 3'd3; opcode = 8'hE1; opnd_a = 8'h55; is_call = 1; step_en = 1; #1;
    chk("R10 push_req", {15'd0, push_req}, 16'h0001);
    chk("R10 return", ret_addr, 16'h3800);
    @(negedge clk);
    chk("R6 call target", pc_q, 16'h3F55);
    step_en = 0; #1;
    chk("R10 no push idle", {15'd0, push_req}, 16'h0000);
    idle_inputs();

    // R1: reset mid-run
    @(negedge clk);
    rst_n = 0; #1;
    chk("R1 async reset", pc_q, 16'h0000);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after second release", pc_q, 16'h0000);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule